// File: doc/BRIEF.md
# Atomic Flash Sector Commit Sequencer

This block drives one logical-block write into flash sectors whose bits can only go from 1 to 0 between erases. A caller hands it a virtual block number, a data word, the address of an erased sector, and optionally the address and 2-bit version of the sector that holds the current copy. The sequencer then issues header and data program commands one at a time on a simple command port. It waits for a done pulse after each command. The order of the commands is fixed, so a power loss at any point leaves a header state that can be told apart from every other.

A combinational recovery classifier sits next to the sequencer and is used at power-up. It is given the header flags, block-number fields and versions of two candidate sectors holding the same block. It reports which copy is live, which copy must be marked obsolete, and which copies were torn and should be queued for erasure.

A build parameter selects the folded mode. In that mode the sector carries no separate free flag, and a block-number field of all ones means the sector is free.

Top module: `flash_commit_seq`

## Requirements
- R1: While reset is held and after its release with no request, `busy` and `cmdValid` are 0.
- R2: In normal mode an accepted write issues commands in this order on `cmdKind`: 1 (clear free flag, new sector), 2 (header block number, new sector), 3 (data, new sector), 4 (clear pre-valid flag, new sector), 5 (clear live flag, old sector). `cmdAddr` is the new sector address for codes 1 to 4 and the old sector address for code 5.
- R3: Each command stays on the port, with its kind, address and data unchanged, until the cycle in which `cmdDone` is high. The next command appears in the cycle after that.
- R4: When `reqHasOld` is 0, code 5 is never issued, and the write ends once the code 4 command completes.
- R5: The code 2 command carries `{version, block number}` in its low VBN_W+2 bits, with the version in the top two bits and zeros above them. The version is `reqOldVer + 1` modulo 4 when an old copy exists and 0 when none exists. The code 3 command carries `reqData`. Codes 1, 4 and 5 carry zero.
- R6: `reqAccept` is high only when `reqValid` is high and `busy` is low. `busy` rises in the cycle after acceptance and falls in the cycle after the last command completes. A request presented while busy is refused and does not change the write in progress.
- R7: In folded mode the code 1 step is skipped, so the first command is code 2. A request whose block number is all ones is refused.
- R8: The classifier treats a sector as used when its free bit is 0; in folded mode it treats a sector as used when its block-number field is not all ones. A used sector whose pre-valid bit is still 1 is reported in `recErase` and is never live.
- R9: A used sector with pre-valid bit 0 and live bit 1 is a good copy. If exactly one copy is good, that copy is live and nothing is marked obsolete. If neither copy is good, nothing is live.
- R10: If both copies are good, B is live and A is marked obsolete when B's version equals A's version plus 1 modulo 4. In every other case A is live and B is marked obsolete. In all outputs bit 0 stands for A and bit 1 for B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request present |
| reqVbn | input | VBN_W | Virtual block number |
| reqNewAddr | input | ADDR_W | Erased target sector |
| reqOldAddr | input | ADDR_W | Sector holding the current copy |
| reqHasOld | input | 1 | An old copy exists |
| reqOldVer | input | 2 | Version of the old copy |
| reqData | input | DATA_W | Data word to program |
| reqAccept | output | 1 | Request taken this cycle |
| busy | output | 1 | Write in progress |
| cmdValid | output | 1 | Command present |
| cmdKind | output | 3 | Command code (see R2) |
| cmdAddr | output | ADDR_W | Command sector address |
| cmdData | output | DATA_W | Command payload |
| cmdDone | input | 1 | Current command finished |
| recAFree | input | 1 | Sector A free bit (1 = free) |
| recAValid | input | 1 | Sector A pre-valid bit (0 = valid) |
| recALive | input | 1 | Sector A live bit (0 = obsolete) |
| recAVer | input | 2 | Sector A version |
| recAVbn | input | VBN_W | Sector A block-number field |
| recBFree | input | 1 | Sector B free bit |
| recBValid | input | 1 | Sector B pre-valid bit |
| recBLive | input | 1 | Sector B live bit |
| recBVer | input | 2 | Sector B version |
| recBVbn | input | VBN_W | Sector B block-number field |
| recKeep | output | 2 | Live copy, one-hot or zero |
| recObsolete | output | 2 | Copy to mark obsolete |
| recErase | output | 2 | Torn copies to queue for erasure |

## Verification
The write path is tried with and without an old copy, with done latencies of zero to three cycles, and with an old version of 3 so that the version wraps to 0. These cases separate the step order, the step skipped when there is no old copy, how long each command is held, and the version arithmetic. A second instance built in folded mode shows the free-flag step removed and the reserved block number refused. Requests presented during a write show that the latched request is not disturbed. The classifier is swept over every combination of the two sectors' flags and versions, with both block-number fields at all ones and at an ordinary value. This separates torn sectors, single good copies, newer-version selection across the wrap, the default choice for equal versions, and the folded way of deciding that a sector is used.

// File: rtl/flash_commit_pkg.sv
package flash_commit_pkg;

  typedef enum logic [2:0] {
    CK_NONE      = 3'd0,
    CK_CLR_FREE  = 3'd1,
    CK_HDR       = 3'd2,
    CK_DATA      = 3'd3,
    CK_SET_VALID = 3'd4,
    CK_OBS_OLD   = 3'd5
  } cmdKind_e;

  typedef struct packed {
    logic     load;
    cmdKind_e step;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_commit_ctrl.sv
module flash_commit_ctrl
  import flash_commit_pkg::*;
#(
  parameter bit FOLD_FREE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqHasOld,
  input  logic        vbnReserved,
  input  logic        cmdDone,
  output logic        reqAccept,
  output logic        busy,
  output ctrlStrobe_t strobe
);

  localparam cmdKind_e FIRST_STEP = FOLD_FREE ? CK_HDR : CK_CLR_FREE;

  cmdKind_e stateQ, stateD;
  logic     hasOldQ;

  assign busy      = (stateQ != CK_NONE);
  assign reqAccept = reqValid && !busy && !(FOLD_FREE && vbnReserved);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CK_NONE:      if (reqAccept) stateD = FIRST_STEP;
      CK_CLR_FREE:  if (cmdDone) stateD = CK_HDR;
      CK_HDR:       if (cmdDone) stateD = CK_DATA;
      CK_DATA:      if (cmdDone) stateD = CK_SET_VALID;
      CK_SET_VALID: if (cmdDone) stateD = hasOldQ ? CK_OBS_OLD : CK_NONE;
      CK_OBS_OLD:   if (cmdDone) stateD = CK_NONE;
      default:      stateD = CK_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= CK_NONE;
      hasOldQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (reqAccept) hasOldQ <= reqHasOld;
    end
  end

  assign strobe.load = reqAccept;
  assign strobe.step = stateQ;

endmodule

// File: rtl/flash_commit_dpath.sv
module flash_commit_dpath
  import flash_commit_pkg::*;
#(
  parameter int VBN_W  = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [VBN_W-1:0]  reqVbn,
  input  logic [ADDR_W-1:0] reqNewAddr,
  input  logic [ADDR_W-1:0] reqOldAddr,
  input  logic              reqHasOld,
  input  logic [1:0]        reqOldVer,
  input  logic [DATA_W-1:0] reqData,
  output logic              vbnReserved,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData
);

  localparam int HDR_W = VBN_W + 2;

  logic [VBN_W-1:0]  vbnQ;
  logic [ADDR_W-1:0] newAddrQ, oldAddrQ;
  logic [1:0]        verQ;
  logic [DATA_W-1:0] dataQ;

  assign vbnReserved = &reqVbn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbnQ     <= '0;
      newAddrQ <= '0;
      oldAddrQ <= '0;
      verQ     <= '0;
      dataQ    <= '0;
    end else if (strobe.load) begin
      vbnQ     <= reqVbn;
      newAddrQ <= reqNewAddr;
      oldAddrQ <= reqOldAddr;
      verQ     <= reqHasOld ? reqOldVer + 2'd1 : 2'd0;
      dataQ    <= reqData;
    end
  end

  logic [HDR_W-1:0] hdrWord;
  assign hdrWord = {verQ, vbnQ};

  assign cmdValid = (strobe.step != CK_NONE);
  assign cmdKind  = strobe.step;
  assign cmdAddr  = (strobe.step == CK_OBS_OLD) ? oldAddrQ : newAddrQ;

  always_comb begin
    cmdData = '0;
    if (strobe.step == CK_HDR)  cmdData = DATA_W'(hdrWord);
    if (strobe.step == CK_DATA) cmdData = dataQ;
  end

endmodule

// File: rtl/flash_recover_class.sv
module flash_recover_class #(
  parameter int VBN_W     = 6,
  parameter bit FOLD_FREE = 1'b0
) (
  input  logic             aFree,
  input  logic             aValid,
  input  logic             aLive,
  input  logic [1:0]       aVer,
  input  logic [VBN_W-1:0] aVbn,
  input  logic             bFree,
  input  logic             bValid,
  input  logic             bLive,
  input  logic [1:0]       bVer,
  input  logic [VBN_W-1:0] bVbn,
  output logic [1:0]       keep,
  output logic [1:0]       obsolete,
  output logic [1:0]       erase
);

  logic [1:0] used, good;
  logic       bNewer;

  generate
    if (FOLD_FREE) begin : g_fold
      assign used = {~&bVbn, ~&aVbn};
    end else begin : g_flag
      assign used = {~bFree, ~aFree};
    end
  endgenerate

  assign erase  = used & {bValid, aValid};
  assign good   = used & {~bValid, ~aValid} & {bLive, aLive};
  assign bNewer = (bVer == aVer + 2'd1);

  always_comb begin
    keep     = 2'b00;
    obsolete = 2'b00;
    unique case (good)
      2'b11: begin
        keep     = bNewer ? 2'b10 : 2'b01;
        obsolete = bNewer ? 2'b01 : 2'b10;
      end
      2'b01:   keep = 2'b01;
      2'b10:   keep = 2'b10;
      default: keep = 2'b00;
    endcase
  end

endmodule

// File: rtl/flash_commit_seq.sv
module flash_commit_seq
  import flash_commit_pkg::*;
#(
  parameter int VBN_W     = 6,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter bit FOLD_FREE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VBN_W-1:0]  reqVbn,
  input  logic [ADDR_W-1:0] reqNewAddr,
  input  logic [ADDR_W-1:0] reqOldAddr,
  input  logic              reqHasOld,
  input  logic [1:0]        reqOldVer,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqAccept,
  output logic              busy,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdDone,
  input  logic              recAFree,
  input  logic              recAValid,
  input  logic              recALive,
  input  logic [1:0]        recAVer,
  input  logic [VBN_W-1:0]  recAVbn,
  input  logic              recBFree,
  input  logic              recBValid,
  input  logic              recBLive,
  input  logic [1:0]        recBVer,
  input  logic [VBN_W-1:0]  recBVbn,
  output logic [1:0]        recKeep,
  output logic [1:0]        recObsolete,
  output logic [1:0]        recErase
);

  ctrlStrobe_t strobe;
  logic        vbnReserved;

  flash_commit_ctrl #(.FOLD_FREE(FOLD_FREE)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHasOld(reqHasOld),
    .vbnReserved(vbnReserved), .cmdDone(cmdDone),
    .reqAccept(reqAccept), .busy(busy), .strobe(strobe)
  );

  flash_commit_dpath #(.VBN_W(VBN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVbn(reqVbn),
    .reqNewAddr(reqNewAddr), .reqOldAddr(reqOldAddr), .reqHasOld(reqHasOld),
    .reqOldVer(reqOldVer), .reqData(reqData), .vbnReserved(vbnReserved),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  flash_recover_class #(.VBN_W(VBN_W), .FOLD_FREE(FOLD_FREE)) u_class (
    .aFree(recAFree), .aValid(recAValid), .aLive(recALive), .aVer(recAVer), .aVbn(recAVbn),
    .bFree(recBFree), .bValid(recBValid), .bLive(recBLive), .bVer(recBVer), .bVbn(recBVbn),
    .keep(recKeep), .obsolete(recObsolete), .erase(recErase)
  );

endmodule

// File: rtl/flash_commit_chk.sv
module flash_commit_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter bit FOLD_FREE = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              reqAccept,
  input logic              cmdValid,
  input logic [2:0]        cmdKind,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdData,
  input logic              cmdDone,
  input logic [1:0]        recKeep,
  input logic [1:0]        recObsolete,
  input logic [1:0]        recErase
);

  localparam logic [2:0] FIRST_CODE = FOLD_FREE ? 3'd2 : 3'd1;

  a_r3_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone |=> cmdValid && $stable(cmdKind) && $stable(cmdAddr) && $stable(cmdData));

  a_r6_cmd_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqAccept);

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> busy);

  a_r7_first_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cmdKind == FIRST_CODE);

  a_r9_single_keep: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(recKeep) && $onehot0(recObsolete));

  a_r10_keep_not_obsolete: assert property (@(posedge clk) disable iff (!rstN)
    (recKeep & recObsolete) == 2'b00);

  a_r8_erase_not_kept: assert property (@(posedge clk) disable iff (!rstN)
    (recErase & recKeep) == 2'b00);

endmodule

bind flash_commit_seq flash_commit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FOLD_FREE(FOLD_FREE)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .reqAccept(reqAccept),
  .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdData(cmdData),
  .cmdDone(cmdDone), .recKeep(recKeep), .recObsolete(recObsolete), .recErase(recErase)
);

// File: tb/test_flash_commit_seq.sv
module test_flash_commit_seq;

  localparam int VBN_W  = 6;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [VBN_W-1:0]  reqVbn = '0;
  logic [ADDR_W-1:0] reqNewAddr = '0, reqOldAddr = '0;
  logic reqHasOld = 1'b0;
  logic [1:0] reqOldVer = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic done = 1'b0;
  logic sel = 1'b0;
  logic aFree = 1, aValid = 1, aLive = 1, bFree = 1, bValid = 1, bLive = 1;
  logic [1:0] aVer = 0, bVer = 0;
  logic [VBN_W-1:0] aVbn = '1, bVbn = '1;

  logic mAcc, mBusy, mVal, fAcc, fBusy, fVal;
  logic [2:0] mKind, fKind;
  logic [ADDR_W-1:0] mAddr, fAddr;
  logic [DATA_W-1:0] mData, fData;
  logic [1:0] mKeep, mObs, mErs, fKeep, fObs, fErs;

  flash_commit_seq #(.VBN_W(VBN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FOLD_FREE(1'b0)) i_flash_commit_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid & ~sel), .reqVbn(reqVbn), .reqNewAddr(reqNewAddr),
    .reqOldAddr(reqOldAddr), .reqHasOld(reqHasOld), .reqOldVer(reqOldVer), .reqData(reqData),
    .reqAccept(mAcc), .busy(mBusy), .cmdValid(mVal), .cmdKind(mKind), .cmdAddr(mAddr),
    .cmdData(mData), .cmdDone(done & ~sel),
    .recAFree(aFree), .recAValid(aValid), .recALive(aLive), .recAVer(aVer), .recAVbn(aVbn),
    .recBFree(bFree), .recBValid(bValid), .recBLive(bLive), .recBVer(bVer), .recBVbn(bVbn),
    .recKeep(mKeep), .recObsolete(mObs), .recErase(mErs));

  flash_commit_seq #(.VBN_W(VBN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FOLD_FREE(1'b1)) i_flash_commit_seq_fold (
    .clk(clk), .rstN(rstN), .reqValid(reqValid & sel), .reqVbn(reqVbn), .reqNewAddr(reqNewAddr),
    .reqOldAddr(reqOldAddr), .reqHasOld(reqHasOld), .reqOldVer(reqOldVer), .reqData(reqData),
    .reqAccept(fAcc), .busy(fBusy), .cmdValid(fVal), .cmdKind(fKind), .cmdAddr(fAddr),
    .cmdData(fData), .cmdDone(done & sel),
    .recAFree(aFree), .recAValid(aValid), .recALive(aLive), .recAVer(aVer), .recAVbn(aVbn),
    .recBFree(bFree), .recBValid(bValid), .recBLive(bLive), .recBVer(bVer), .recBVbn(bVbn),
    .recKeep(fKeep), .recObsolete(fObs), .recErase(fErs));

  wire vAcc  = sel ? fAcc  : mAcc;
  wire vBusy = sel ? fBusy : mBusy;
  wire vVal  = sel ? fVal  : mVal;
  wire [2:0] vKind = sel ? fKind : mKind;
  wire [ADDR_W-1:0] vAddr = sel ? fAddr : mAddr;
  wire [DATA_W-1:0] vData = sel ? fData : mData;

  int checkCount = 0;
  int failCount  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runWrite(input bit useFold, input int vbn, input int newA, input int oldA,
                          input bit hasOld, input int oldVer, input int dat, input int lat,
                          input bit poke);
    int kinds[5];
    int addrs[5];
    int datas[5];
    int n = 0;
    int ver;
    ver = hasOld ? ((oldVer + 1) % 4) : 0;
    if (!useFold) begin kinds[n] = 1; addrs[n] = newA; datas[n] = 0; n++; end
    kinds[n] = 2; addrs[n] = newA; datas[n] = (ver << VBN_W) | vbn; n++;
    kinds[n] = 3; addrs[n] = newA; datas[n] = dat; n++;
    kinds[n] = 4; addrs[n] = newA; datas[n] = 0; n++;
    if (hasOld) begin kinds[n] = 5; addrs[n] = oldA; datas[n] = 0; n++; end

    sel = useFold;
    reqVbn = VBN_W'(vbn); reqNewAddr = ADDR_W'(newA); reqOldAddr = ADDR_W'(oldA);
    reqHasOld = hasOld; reqOldVer = 2'(oldVer); reqData = DATA_W'(dat);
    reqValid = 1'b1;
    #1;
    chk(vAcc == 1'b1, "R6 accept when idle", int'(vAcc), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(vBusy == 1'b1, "R6 busy after accept", int'(vBusy), 1);
    for (int i = 0; i < n; i++) begin
      chk(vVal == 1'b1, "R3 command present", int'(vVal), 1);
      chk(int'(vKind) == kinds[i], useFold ? "R7 step order folded" : "R2 step order", int'(vKind), kinds[i]);
      chk(int'(vAddr) == addrs[i], "R2 step address", int'(vAddr), addrs[i]);
      chk(int'(vData) == datas[i], "R5 step payload", int'(vData), datas[i]);
      for (int k = 0; k < lat; k++) begin
        if (poke && i == 0 && k == 0) begin
          reqValid = 1'b1; reqVbn = ~reqVbn; reqNewAddr = ~reqNewAddr;
          reqOldAddr = ~reqOldAddr; reqOldVer = ~reqOldVer; reqData = ~reqData;
          #1;
          chk(vAcc == 1'b0, "R6 refuse while busy", int'(vAcc), 0);
        end
        @(negedge clk);
        reqValid = 1'b0;
        chk(int'(vKind) == kinds[i] && int'(vAddr) == addrs[i] && int'(vData) == datas[i],
            "R3 held until done", int'(vKind), kinds[i]);
        chk(vBusy == 1'b1, "R6 busy during write", int'(vBusy), 1);
      end
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    chk(vBusy == 1'b0, hasOld ? "R6 busy falls after last" : "R4 ends after valid step", int'(vBusy), 0);
    chk(vVal == 1'b0, "R4 no further command", int'(vVal), 0);
    @(negedge clk);
    chk(vVal == 1'b0 && vBusy == 1'b0, "R4 stays idle", int'(vVal), 0);
  endtask

  function automatic logic [5:0] expClass(input bit fold);
    logic [1:0] used, good, keep, obs, ers;
    used[0] = fold ? (aVbn != '1) : !aFree;
    used[1] = fold ? (bVbn != '1) : !bFree;
    ers  = {used[1] & bValid, used[0] & aValid};
    good = {used[1] & !bValid & bLive, used[0] & !aValid & aLive};
    keep = 2'b00; obs = 2'b00;
    if (good == 2'b11) begin
      if (int'(bVer) == (int'(aVer) + 1) % 4) begin keep = 2'b10; obs = 2'b01; end
      else begin keep = 2'b01; obs = 2'b10; end
    end else keep = good;
    return {ers, obs, keep};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [5:0] e;
    repeat (3) @(negedge clk);
    chk(mBusy == 1'b0 && mVal == 1'b0, "R1 reset state", int'(mBusy), 0);
    chk(fBusy == 1'b0 && fVal == 1'b0, "R1 reset state folded", int'(fBusy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(mBusy == 1'b0 && mVal == 1'b0, "R1 idle after reset", int'(mVal), 0);

    runWrite(1'b0, 6'h15, 8'h21, 8'h40, 1'b1, 3, 16'hA5C3, 0, 1'b0);
    runWrite(1'b0, 6'h2A, 8'h22, 8'h00, 1'b0, 0, 16'h1234, 2, 1'b0);
    runWrite(1'b0, 6'h07, 8'h30, 8'h31, 1'b1, 1, 16'hBEEF, 3, 1'b1);
    runWrite(1'b1, 6'h3E, 8'h50, 8'h51, 1'b1, 2, 16'h0F0F, 1, 1'b0);
    runWrite(1'b1, 6'h00, 8'h52, 8'h00, 1'b0, 0, 16'hFFFF, 2, 1'b1);

    sel = 1'b1; reqVbn = '1; reqValid = 1'b1;
    #1;
    chk(fAcc == 1'b0, "R7 reserved number refused", int'(fAcc), 0);
    @(negedge clk);
    reqValid = 1'b0;
    chk(fBusy == 1'b0 && fVal == 1'b0, "R7 no write started", int'(fBusy), 0);
    sel = 1'b0;

    for (int v = 0; v < 4; v++) begin
      for (int code = 0; code < 1024; code++) begin
        {aFree, aValid, aLive, aVer, bFree, bValid, bLive, bVer} = 10'(code);
        aVbn = v[0] ? 6'h05 : '1;
        bVbn = v[1] ? 6'h05 : '1;
        @(negedge clk);
        e = expClass(1'b0);
        chk(mErs == e[5:4], "R8 erase flags", int'(mErs), int'(e[5:4]));
        chk(mObs == e[3:2], "R10 obsolete choice", int'(mObs), int'(e[3:2]));
        chk(mKeep == e[1:0], "R9 live copy", int'(mKeep), int'(e[1:0]));
        e = expClass(1'b1);
        chk(fErs == e[5:4] && fObs == e[3:2] && fKeep == e[1:0], "R8 folded used test",
            int'({fErs, fObs, fKeep}), int'(e));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule